// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference input against a feedback input coming back from an oscillator, and it reacts only to their rising edges. Both inputs are asynchronous to a fast system clock. Each passes through a synchroniser and then a rising-edge detector. A three-state machine then records which edge arrived first. The machine drives one three-state correction output, which is modelled as a data bit and an output-enable bit. It also drives a phase pulse that is high whenever the two edges are out of alignment.

When the reference edge leads, the correction output is driven high until the matching feedback edge arrives. When the feedback edge leads, the output is driven low until the matching reference edge arrives. At all other times the output is released. A loop built around the block therefore settles at zero phase error between the two rising edges. In lock, the output is released for almost all of the time. Because a repeated edge does not cancel a pump state that is already active, the block also pulls the loop toward the correct frequency.

Top module: `edge_pfd`

## Requirements
- R1: A synchronous active-high reset puts the detector in the released state, with pump_oe = 0, pump_data = 0 and phase_pulse = 0 from the first clock edge on which reset is sampled high.
- R2: A rising edge on ref_in while the detector is released, with no feedback rising edge detected in the same cycle, drives pump_oe = 1 and pump_data = 1.
- R3: While pumping high, the output holds pump_oe = 1 and pump_data = 1 until a feedback rising edge is detected. The output then returns to released (pump_oe = 0).
- R4: A rising edge on fb_in while the detector is released, with no reference rising edge detected in the same cycle, drives pump_oe = 1 and pump_data = 0.
- R5: While pumping low, the output holds pump_oe = 1 and pump_data = 0 until a reference rising edge is detected. The output then returns to released.
- R6: If rising edges on both inputs are detected in the same system clock cycle, the detector stays in the released state or returns to it, whatever its state was before.
- R7: A further reference rising edge while pumping high keeps the detector pumping high. A further feedback rising edge while pumping low keeps it pumping low.
- R8: Falling edges and input duty cycle have no effect. An input level held high or low produces no change, and each rising edge counts only once.
- R9: phase_pulse is 1 exactly when pump_oe is 1, in both pump directions.
- R10: A level change on an input is seen at the outputs on the third rising clock edge after the change: two synchroniser stages plus the state register. It is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both inputs |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator, asynchronous |
| pump_data | output | 1 | Driven level when enabled: 1 high, 0 low |
| pump_oe | output | 1 | Output enable of the correction output; 0 means released |
| phase_pulse | output | 1 | High while the edges are misaligned (pumping) |

## Verification
The assertions assume that each input changes level at most once per system clock period. They also assume that the inputs are sampled cleanly once they are past the synchroniser, so every detected rising edge lasts exactly one cycle. The stimulus changes ref_in and fb_in only on the falling clock edge, one level per cycle. This keeps every edge well inside the sampling window and lets the bench place edges in the same cycle or in chosen cycles on purpose. The expected outputs come from a model of the requirements that is updated for each driven level and checked three cycles later.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_RELEASED = 2'd0,
        ST_PUMP_HI  = 2'd1,
        ST_PUMP_LO  = 2'd2
    } pfd_state_e;

    typedef struct packed {
        pfd_state_e state;
        logic       oe;
        logic       data;
        logic       pulse;
    } pfd_regs_t;

    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;
    localparam int NUM_INPUTS = 2;

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_rise
        assign rise[g] = level[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic pump_oe,
    output logic pump_data,
    output logic phase_pulse
);
    pfd_regs_t r_d, r_q;
    pfd_state_e nxt;

    always_comb begin
        nxt = r_q.state;
        unique case (r_q.state)
            ST_RELEASED: begin
                if (ref_rise && !fb_rise)      nxt = ST_PUMP_HI;
                else if (fb_rise && !ref_rise) nxt = ST_PUMP_LO;
                else                           nxt = ST_RELEASED;
            end
            ST_PUMP_HI: begin
                if (fb_rise) nxt = ST_RELEASED;
                else         nxt = ST_PUMP_HI;
            end
            ST_PUMP_LO: begin
                if (ref_rise) nxt = ST_RELEASED;
                else          nxt = ST_PUMP_LO;
            end
            default: nxt = ST_RELEASED;
        endcase
        r_d.state = nxt;
        r_d.oe    = (nxt != ST_RELEASED);
        r_d.data  = (nxt == ST_PUMP_HI);
        r_d.pulse = (nxt == ST_PUMP_HI) || (nxt == ST_PUMP_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_RELEASED, oe: 1'b0, data: 1'b0, pulse: 1'b0};
        else     r_q <= r_d;
    end

    assign pump_oe     = r_q.oe;
    assign pump_data   = r_q.data;
    assign phase_pulse = r_q.pulse;
endmodule

// File: rtl/edge_pfd.sv
module edge_pfd
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic pump_data,
    output logic pump_oe,
    output logic phase_pulse
);
    logic [NUM_INPUTS-1:0] raw_in, synced, rises;
    logic ref_rise, fb_rise;

    assign raw_in[IDX_REF] = ref_in;
    assign raw_in[IDX_FB]  = fb_in;

    pfd_sync #(.WIDTH(NUM_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(raw_in), .sync_out(synced)
    );

    pfd_edge #(.WIDTH(NUM_INPUTS)) u_edge (
        .clk(clk), .rst(rst), .level(synced), .rise(rises)
    );

    assign ref_rise = rises[IDX_REF];
    assign fb_rise  = rises[IDX_FB];

    pfd_fsm u_fsm (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .pump_oe(pump_oe), .pump_data(pump_data), .phase_pulse(phase_pulse)
    );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic clk,
    input logic rst,
    input logic ref_rise,
    input logic fb_rise,
    input logic pump_oe,
    input logic pump_data,
    input logic phase_pulse
);
    // R1
    a_r1_reset_released: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pump_oe && !phase_pulse));
    // R2
    a_r2_ref_lead: assert property (@(posedge clk) disable iff (rst)
        (!pump_oe && ref_rise && !fb_rise) |=> (pump_oe && pump_data));
    // R3
    a_r3_hold_high: assert property (@(posedge clk) disable iff (rst)
        (pump_oe && pump_data && !fb_rise) |=> (pump_oe && pump_data));
    a_r3_release_high: assert property (@(posedge clk) disable iff (rst)
        (pump_oe && pump_data && fb_rise) |=> !pump_oe);
    // R4
    a_r4_fb_lead: assert property (@(posedge clk) disable iff (rst)
        (!pump_oe && fb_rise && !ref_rise) |=> (pump_oe && !pump_data));
    // R5
    a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
        (pump_oe && !pump_data && !ref_rise) |=> (pump_oe && !pump_data));
    a_r5_release_low: assert property (@(posedge clk) disable iff (rst)
        (pump_oe && !pump_data && ref_rise) |=> !pump_oe);
    // R6
    a_r6_both_release: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> !pump_oe);
    // R8
    a_r8_ref_single: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> !ref_rise);
    a_r8_fb_single: assert property (@(posedge clk) disable iff (rst)
        fb_rise |=> !fb_rise);
    // R8
    a_r8_quiet_stable: assert property (@(posedge clk) disable iff (rst)
        (!ref_rise && !fb_rise) |=> ($stable(pump_oe) && $stable(pump_data)));
    // R9
    a_r9_pulse_tracks: assert property (@(posedge clk) disable iff (rst)
        phase_pulse == pump_oe);
endmodule

bind edge_pfd pfd_checker u_chk (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .pump_oe(pump_oe), .pump_data(pump_data), .phase_pulse(phase_pulse)
);

// File: tb/sim_edge_pfd.sv
`timescale 1ns/1ps
module sim_edge_pfd;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic pump_data, pump_oe, phase_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // scoreboard queues
    int    q_when[$];
    bit    q_oe[$];
    bit    q_data[$];
    string q_tag[$];

    // model state: 0 released, 1 high, 2 low
    int  m_state = 0;
    bit  m_ref = 0;
    bit  m_fb = 0;

    edge_pfd u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .pump_data(pump_data), .pump_oe(pump_oe), .phase_pulse(phase_pulse)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    // driver: apply levels for one cycle and push the expected result
    task automatic step(input bit r, input bit f, input string tag);
        bit rr, fr;
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
        rr = r & ~m_ref;
        fr = f & ~m_fb;
        m_ref = r;
        m_fb  = f;
        case (m_state)
            0: m_state = (rr && !fr) ? 1 : ((fr && !rr) ? 2 : 0);
            1: m_state = fr ? 0 : 1;
            default: m_state = rr ? 0 : 2;
        endcase
        q_when.push_back(cyc + 3);
        q_oe.push_back(m_state != 0);
        q_data.push_back(m_state == 1);
        q_tag.push_back(tag);
    endtask

    task automatic hold(input bit r, input bit f, input int n, input string tag);
        for (int i = 0; i < n; i++) step(r, f, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_when.size() > 0 && q_when[0] == cyc) begin
                int w;
                bit eo, ed;
                string t;
                w  = q_when.pop_front();
                eo = q_oe.pop_front();
                ed = q_data.pop_front();
                t  = q_tag.pop_front();
                check(pump_oe == eo, t, "pump_oe", pump_oe, eo);
                if (eo) check(pump_data == ed, t, "pump_data", pump_data, ed);
                check(phase_pulse == eo, "R9", "phase_pulse", phase_pulse, eo);
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(pump_oe == 0, "R1", "pump_oe in reset", pump_oe, 0);
        check(phase_pulse == 0, "R1", "phase_pulse in reset", phase_pulse, 0);
        @(negedge clk);
        rst = 1'b0;
        hold(0, 0, 4, "R1");

        // R2 then R3: reference leads, feedback closes; R10 latency on each cycle
        step(1, 0, "R10");
        hold(1, 0, 5, "R3");
        step(1, 1, "R3");
        hold(1, 1, 3, "R8");
        hold(0, 0, 3, "R8");

        // R4 then R5: feedback leads
        step(0, 1, "R4");
        hold(0, 1, 4, "R5");
        step(1, 1, "R5");
        hold(0, 0, 3, "R8");

        // R6: simultaneous edges from released
        step(1, 1, "R6");
        hold(0, 0, 3, "R6");
        // R6: simultaneous edges while pumping high
        step(1, 0, "R2");
        hold(0, 0, 2, "R8");
        step(1, 1, "R6");
        hold(0, 0, 3, "R6");
        // R6: simultaneous edges while pumping low
        step(0, 1, "R4");
        hold(0, 0, 2, "R8");
        step(1, 1, "R6");
        hold(0, 0, 3, "R6");

        // R7: repeated reference edges while high
        step(1, 0, "R2");
        hold(0, 0, 2, "R7");
        step(1, 0, "R7");
        hold(0, 0, 2, "R7");
        step(1, 0, "R7");
        step(1, 1, "R3");
        hold(0, 0, 3, "R3");
        // R7: repeated feedback edges while low
        step(0, 1, "R4");
        hold(0, 0, 2, "R7");
        step(0, 1, "R7");
        hold(0, 0, 1, "R7");
        step(0, 1, "R7");
        step(1, 1, "R5");
        hold(0, 0, 3, "R5");

        // R8: narrow versus wide reference pulses, no feedback
        step(1, 0, "R8");
        hold(0, 0, 6, "R8");
        step(1, 0, "R8");
        hold(1, 0, 8, "R8");
        hold(0, 0, 2, "R8");
        step(0, 1, "R3");
        hold(0, 1, 6, "R8");
        hold(0, 0, 4, "R8");

        // R2/R3 with spacing: reference leads by one cycle
        step(1, 0, "R2");
        step(1, 1, "R3");
        hold(0, 0, 3, "R3");
        // R4/R5: feedback leads by one cycle
        step(0, 1, "R4");
        step(1, 1, "R5");
        hold(0, 0, 6, "R5");

        // R1: reset while pumping
        step(1, 0, "R2");
        hold(1, 0, 4, "R2");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pump_oe == 0, "R1", "pump_oe after reset", pump_oe, 0);
        check(phase_pulse == 0, "R1", "phase_pulse after reset", phase_pulse, 0);
        q_when.delete(); q_oe.delete(); q_data.delete(); q_tag.delete();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule